// File: doc/BRIEF.md
# Streaming FIR Filter Engine

This block filters a stream of signed samples with a fixed set of taps. It keeps one multiplier and one adder busy. Samples enter on an AXI4-Stream slave and results leave on an AXI4-Stream master. The master raises `tlast` on the result that belongs to the final sample of a run. Coefficients come from an external word-addressed RAM through a read port with one cycle of latency. The sample history lives in a private RAM that the engine treats as a ring and walks backwards from the newest word.

Software sets up a run by presenting the run length on `run_len` and pulsing `ap_start`. The engine then wipes the history ring, so every run starts from zero history, and accepts exactly `run_len` samples. When the last result has been taken, `ap_idle` and `ap_done` rise. Each result costs one multiply-accumulate per tap. Intake of the next sample overlaps the last read of the current one, so the engine accepts a new sample every TAPS cycles when nothing downstream stalls. One finished result can wait in the output register and a second can be parked behind it. While a result is parked, intake stops.

The controller has four states:
- `ST_IDLE` goes to `ST_CLEAR` when `ap_start` is high.
- `ST_CLEAR` goes to `ST_STREAM` after it has written the last ring word.
- `ST_STREAM` goes to `ST_FLUSH` when it accepts the final sample.
- `ST_FLUSH` goes to `ST_IDLE` when the `tlast` result is handed over.

Top module: `fir_stream_engine`

## Requirements
- R1: Out of reset, `ap_idle`=1, `ap_done`=0, `ss_tready`=0 and `sm_tvalid`=0.
- R2: The cycle after `ap_start` is seen high while the engine is idle, `ap_idle` and `ap_done` read 0. An `ap_start` pulse while the engine is busy has no effect: no new clear phase begins and `ss_tready` stays as it was.
- R3: After a start, the engine writes zero to all TAPS ring words, one word per cycle. `ss_tready` stays 0 through this phase and first rises TAPS cycles after the first cycle in which `ap_idle` reads 0.
- R4: Result n equals the sum over k=0..TAPS-1 of c[k]·x[n−k]. Samples from before the first sample of the run count as 0. All arithmetic is 32-bit two's complement and wraps modulo 2^32.
- R5: Coefficient k is read at byte address 4·k, with `coef_en` high during the read. Its data is taken from `coef_rdata` one cycle later. Addresses stay word-aligned and never exceed 4·(TAPS−1).
- R6: With the output free, a sample's result shows `sm_tvalid`=1 exactly 12 clock edges after the edge that accepted the sample (TAPS=11).
- R7: With the output always ready and samples always offered, consecutive samples are accepted exactly TAPS cycles apart.
- R8: The engine holds at most two results: one in the output register and one parked behind it. While a result is parked, `ss_tready` is 0. With `sm_tready` held low from the start of a run, exactly three samples are accepted.
- R9: While `sm_tvalid`=1 and `sm_tready`=0, `sm_tvalid` and `sm_tdata` keep their values on the next cycle.
- R10: `sm_tlast` is 1 only with the result of sample number `run_len`. No sample is accepted after that one. `run_len` must be at least 1.
- R11: `ap_done` stays 0 until the `tlast` handshake. On the cycle after that handshake, `ap_idle`=1 and `ap_done`=1, and `ap_done` holds until the next start.
- R12: The history ring is cleared at every start, so the first result of a run is c[0]·x[0] whatever the previous run left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ap_start | input | 1 | Start pulse, acted on only when idle |
| run_len | input | LW | Number of samples in the run (at least 1) |
| ss_tdata | input | DW | Input sample, signed |
| ss_tvalid | input | 1 | Input sample valid |
| ss_tready | output | 1 | Engine can accept a sample |
| sm_tdata | output | DW | Filtered result, signed |
| sm_tvalid | output | 1 | Result valid |
| sm_tready | input | 1 | Downstream accepts the result |
| sm_tlast | output | 1 | Marks the result of the final sample |
| ap_idle | output | 1 | High while no run is active |
| ap_done | output | 1 | High after a run has completed |
| coef_en | output | 1 | Coefficient read enable |
| coef_addr | output | AW | Coefficient byte address |
| coef_rdata | input | DW | Coefficient read data, one cycle after the address |

## Verification
The bench builds the engine with its defaults: TAPS=11, DW=32, LW=16 and AW=12. These defaults make the 12-edge latency and the 11-cycle intake spacing exact numbers that the bench can check.

Three runs exercise the design:
- The first run uses small coefficients and a ramp of inputs.
- The second run uses coefficients near the top of the 32-bit range, so the products wrap. It also holds the output stalled long enough to park a result and starve intake. Because it follows a finished run, it also shows that the history was wiped.
- The last run is a single-sample run under a toggling `sm_tready`, so its only result also carries `tlast`.

// File: rtl/fir_stream_pkg.sv
package fir_stream_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_STREAM,
        ST_FLUSH
    } fir_state_e;
endpackage

// File: rtl/fir_sample_ram.sv
// History ring storage: one write port, one registered read port, read-before-write.
module fir_sample_ram #(
    parameter int DEPTH = 11,
    parameter int DW    = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [IW-1:0]        waddr,
    input  logic signed [DW-1:0] wdata,
    input  logic                 re,
    input  logic [IW-1:0]        raddr,
    output logic signed [DW-1:0] rdata
);
    logic signed [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (re)
            rdata <= mem[raddr];
        if (we)
            mem[waddr] <= wdata;
    end

    assert property (@(posedge clk) we |-> (int'(waddr) < DEPTH))
        else $error("ring write index out of range");
    assert property (@(posedge clk) re |-> (int'(raddr) < DEPTH))
        else $error("ring read index out of range");
endmodule

// File: rtl/fir_out_slot.sv
// Output register plus one parked result; the parked flag throttles intake upstream.
module fir_out_slot #(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_v,
    input  logic signed [DW-1:0] in_d,
    input  logic                 in_last,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data,
    output logic                 out_last,
    output logic                 held
);
    logic                 full_q, last_q, park_last;
    logic signed [DW-1:0] data_q, park_d;
    logic                 take;

    assign take      = full_q && out_ready;
    assign out_valid = full_q;
    assign out_data  = data_q;
    assign out_last  = last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q    <= 1'b0;
            last_q    <= 1'b0;
            data_q    <= '0;
            held      <= 1'b0;
            park_d    <= '0;
            park_last <= 1'b0;
        end else if (held && take) begin
            data_q <= park_d;
            last_q <= park_last;
            held   <= 1'b0;
        end else if (in_v && (!full_q || take)) begin
            data_q <= in_d;
            last_q <= in_last;
            full_q <= 1'b1;
        end else if (in_v) begin
            park_d    <= in_d;
            park_last <= in_last;
            held      <= 1'b1;
        end else if (take) begin
            full_q <= 1'b0;
            last_q <= 1'b0;
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)))
        else $error("R9 output changed while stalled");
    assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_v |-> !held)
        else $error("R8 result arrived while one is already parked");
endmodule

// File: rtl/fir_stream_engine.sv
module fir_stream_engine
    import fir_stream_pkg::*;
#(
    parameter int TAPS = 11,
    parameter int DW   = 32,
    parameter int LW   = 16,
    parameter int AW   = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ap_start,
    input  logic [LW-1:0]        run_len,
    input  logic signed [DW-1:0] ss_tdata,
    input  logic                 ss_tvalid,
    output logic                 ss_tready,
    output logic signed [DW-1:0] sm_tdata,
    output logic                 sm_tvalid,
    input  logic                 sm_tready,
    output logic                 sm_tlast,
    output logic                 ap_idle,
    output logic                 ap_done,
    output logic                 coef_en,
    output logic [AW-1:0]        coef_addr,
    input  logic signed [DW-1:0] coef_rdata
);
    localparam int IW = (TAPS > 1) ? $clog2(TAPS) : 1;
    localparam logic [IW-1:0] LAST = IW'(TAPS - 1);

    fir_state_e state, nxt;

    logic [IW-1:0]        clr_idx, wp, rd_idx, rd_k;
    logic                 rd_busy, rd_final;
    logic [LW-1:0]        got;
    logic                 mac_v, mac_first, mac_last, mac_final;
    logic signed [DW-1:0] acc, smp, prod, sum;
    logic                 done_q, held, take, rd_go, ss_fire, is_final;
    logic                 ram_we;
    logic [IW-1:0]        ram_waddr;
    logic signed [DW-1:0] ram_wdata;

    // ---------------- control decode ----------------
    assign take      = sm_tvalid && sm_tready;
    assign rd_go     = rd_busy && !held;
    assign ss_tready = (state == ST_STREAM) && !held && (!rd_busy || rd_k == LAST);
    assign ss_fire   = ss_tvalid && ss_tready;
    assign is_final  = (got + LW'(1)) == run_len;
    assign ap_idle   = (state == ST_IDLE);
    assign ap_done   = done_q;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (ap_start)                nxt = ST_CLEAR;
            ST_CLEAR:  if (clr_idx == LAST)         nxt = ST_STREAM;
            ST_STREAM: if (ss_fire && is_final)     nxt = ST_FLUSH;
            ST_FLUSH:  if (take && sm_tlast)        nxt = ST_IDLE;
            default:                                nxt = ST_IDLE;
        endcase
    end

    // ---------------- outputs and datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_idx   <= '0;
            wp        <= '0;
            got       <= '0;
            done_q    <= 1'b0;
            rd_busy   <= 1'b0;
            rd_k      <= '0;
            rd_idx    <= '0;
            rd_final  <= 1'b0;
            mac_v     <= 1'b0;
            mac_first <= 1'b0;
            mac_last  <= 1'b0;
            mac_final <= 1'b0;
            acc       <= '0;
        end else begin
            if (state == ST_IDLE && ap_start) begin
                clr_idx <= '0;
                wp      <= '0;
                got     <= '0;
                done_q  <= 1'b0;
            end else if (state == ST_CLEAR) begin
                clr_idx <= clr_idx + IW'(1);
            end
            if (state == ST_FLUSH && take && sm_tlast)
                done_q <= 1'b1;

            if (ss_fire) begin
                wp       <= (wp == LAST) ? '0 : wp + IW'(1);
                got      <= got + LW'(1);
                rd_busy  <= 1'b1;
                rd_k     <= '0;
                rd_idx   <= wp;
                rd_final <= is_final;
            end else if (rd_go) begin
                if (rd_k == LAST) begin
                    rd_busy <= 1'b0;
                end else begin
                    rd_k   <= rd_k + IW'(1);
                    rd_idx <= (rd_idx == '0) ? LAST : rd_idx - IW'(1);
                end
            end

            mac_v     <= rd_go;
            mac_first <= (rd_k == '0);
            mac_last  <= (rd_k == LAST);
            mac_final <= rd_final;
            if (mac_v)
                acc <= sum;
        end
    end

    assign coef_en   = rd_go;
    assign coef_addr = AW'({rd_k, 2'b00});
    assign prod      = coef_rdata * smp;
    assign sum       = (mac_first ? '0 : acc) + prod;

    assign ram_we    = (state == ST_CLEAR) || ss_fire;
    assign ram_waddr = (state == ST_CLEAR) ? clr_idx : wp;
    assign ram_wdata = (state == ST_CLEAR) ? '0 : ss_tdata;

    fir_sample_ram #(.DEPTH(TAPS), .DW(DW)) u_ring (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (rd_go),
        .raddr (rd_idx),
        .rdata (smp)
    );

    fir_out_slot #(.DW(DW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_v      (mac_v && mac_last),
        .in_d      (sum),
        .in_last   (mac_final),
        .out_ready (sm_tready),
        .out_valid (sm_tvalid),
        .out_data  (sm_tdata),
        .out_last  (sm_tlast),
        .held      (held)
    );

    // ---------------- assertions ----------------
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ap_start) |=> (!ap_idle && !ap_done))
        else $error("R2 start not taken");
    assert_clear_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |-> !ss_tready)
        else $error("R3 intake open during clear");
    assert_coef_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        coef_en |-> (coef_addr[1:0] == 2'b00 && int'(coef_addr) <= 4 * (TAPS - 1)))
        else $error("R5 coefficient address out of range");
    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !ss_tready)
        else $error("R8 intake open while a result is parked");
    assert_no_intake_after_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |-> !ss_tready)
        else $error("R10 intake after final sample");
    assert_finish_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_tvalid && sm_tready && sm_tlast) |=> (ap_idle && ap_done))
        else $error("R11 completion flags not raised");
endmodule

// File: tb/fir_stream_engine_bench.sv
module fir_stream_engine_bench;
    localparam int TAPS = 11;
    localparam int DW   = 32;
    localparam int LW   = 16;
    localparam int AW   = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ap_start = 1'b0;
    logic [LW-1:0]        run_len = '0;
    logic signed [DW-1:0] ss_tdata = '0;
    logic                 ss_tvalid = 1'b0;
    logic                 ss_tready;
    logic signed [DW-1:0] sm_tdata;
    logic                 sm_tvalid;
    logic                 sm_tready = 1'b0;
    logic                 sm_tlast, ap_idle, ap_done, coef_en;
    logic [AW-1:0]        coef_addr;
    logic signed [DW-1:0] coef_rdata = '0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int fed = 0;
    int coef_bad = 0;
    logic signed [DW-1:0] coefs [TAPS];
    logic signed [DW-1:0] xs [32];
    int fire_cyc [32];

    fir_stream_engine #(.TAPS(TAPS), .DW(DW), .LW(LW), .AW(AW)) u_fir_stream_engine (
        .clk(clk), .rst_n(rst_n), .ap_start(ap_start), .run_len(run_len),
        .ss_tdata(ss_tdata), .ss_tvalid(ss_tvalid), .ss_tready(ss_tready),
        .sm_tdata(sm_tdata), .sm_tvalid(sm_tvalid), .sm_tready(sm_tready), .sm_tlast(sm_tlast),
        .ap_idle(ap_idle), .ap_done(ap_done),
        .coef_en(coef_en), .coef_addr(coef_addr), .coef_rdata(coef_rdata)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // coefficient RAM model: one cycle read latency (R5)
    always @(posedge clk) if (coef_en) coef_rdata <= coefs[int'(coef_addr) >> 2];
    always @(negedge clk)
        if (rst_n && coef_en && (coef_addr[1:0] != 2'b00 || int'(coef_addr) > 4 * (TAPS - 1)))
            coef_bad++;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic signed [DW-1:0] ref_y(input int j);
        logic signed [DW-1:0] a = '0;
        for (int k = 0; k < TAPS; k++)
            if (j - k >= 0) a = a + coefs[k] * xs[j - k];
        return a;
    endfunction

    task automatic do_start();
        @(negedge clk) ap_start = 1'b1;
        @(negedge clk) ap_start = 1'b0;
        check(ap_idle == 1'b0, "R2", "ap_idle after start", ap_idle, 0);
        check(ap_done == 1'b0, "R2", "ap_done after start", ap_done, 0);
    endtask

    task automatic wait_clear();
        int n = 0;
        while (!ss_tready && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n == TAPS, "R3", "cycles until ss_tready", n, TAPS);
    endtask

    task automatic run_case(input int n, input int mode, input bit poke);
        int j, waits, first, gap_bad;
        bit prev_stall;
        logic signed [DW-1:0] prev_d;
        run_len = LW'(n);
        do_start();
        wait_clear();
        if (poke) begin
            ap_start = 1'b1;
            @(negedge clk);
            ap_start = 1'b0;
            check(ss_tready && !ap_idle, "R2", "start while busy ignored",
                  {ss_tready, ap_idle}, 2);
        end
        fed = 0;
        j = 0;
        waits = 0;
        first = -1;
        prev_stall = 1'b0;
        prev_d = '0;
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    ss_tdata  = xs[i];
                    ss_tvalid = 1'b1;
                    while (!ss_tready) @(negedge clk);
                    @(posedge clk);
                    #1;
                    fire_cyc[i] = cyc;
                    fed++;
                end
                ss_tvalid = 1'b0;
            end
            begin
                while (j < n && waits < 5000) begin
                    @(negedge clk);
                    waits++;
                    case (mode)
                        0:       sm_tready = 1'b1;
                        1:       sm_tready = (waits > 70);
                        default: sm_tready = waits[0];
                    endcase
                    if (mode == 1 && waits == 70) begin
                        check(fed == 3, "R8", "samples accepted under full stall", fed, 3);
                        check(!ss_tready, "R8", "ss_tready while result parked", ss_tready, 0);
                    end
                    if (prev_stall)
                        check(sm_tvalid && sm_tdata == prev_d, "R9", "stalled output held",
                              sm_tdata, prev_d);
                    prev_stall = sm_tvalid && !sm_tready;
                    prev_d     = sm_tdata;
                    if (sm_tvalid && first < 0) first = cyc;
                    if (sm_tvalid && sm_tready) begin
                        check(sm_tdata == ref_y(j), "R4/R12", "result value", sm_tdata, ref_y(j));
                        check(sm_tlast == (j == n - 1), "R10", "tlast placement",
                              sm_tlast, (j == n - 1));
                        if (j == n - 1)
                            check(!ap_done, "R11", "ap_done before final handshake", ap_done, 0);
                        j++;
                    end
                end
                @(negedge clk);
                check(ap_idle && ap_done, "R11", "idle and done after final handshake",
                      {ap_idle, ap_done}, 3);
            end
        join
        sm_tready = 1'b0;
        if (mode == 0) begin
            check(first == fire_cyc[0] + 12, "R6", "first result latency",
                  first - fire_cyc[0], 12);
            gap_bad = 0;
            for (int i = 1; i < n; i++)
                if (fire_cyc[i] - fire_cyc[i - 1] != TAPS) gap_bad++;
            check(gap_bad == 0, "R7", "intake spacing mismatches", gap_bad, 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ap_idle == 1'b1, "R1", "ap_idle after reset", ap_idle, 1);
        check(ap_done == 1'b0, "R1", "ap_done after reset", ap_done, 0);
        check(ss_tready == 1'b0, "R1", "ss_tready after reset", ss_tready, 0);
        check(sm_tvalid == 1'b0, "R1", "sm_tvalid after reset", sm_tvalid, 0);

        // small coefficients, ramp input, free-running output
        for (int k = 0; k < TAPS; k++) coefs[k] = DW'(k - 3);
        for (int i = 0; i < 32; i++) xs[i] = DW'(i * 7 - 40);
        run_case(15, 0, 1'b0);
        check(coef_bad == 0, "R5", "misaligned or out-of-range coefficient reads", coef_bad, 0);

        // wrapping magnitudes, stalled output, restart after a finished run
        for (int k = 0; k < TAPS; k++) coefs[k] = DW'(32'h7000_0000 + k * 32'h0135_7931);
        for (int i = 0; i < 32; i++) xs[i] = DW'(32'h0123_4567 * (i + 3) ^ 32'h8000_0001);
        run_case(12, 1, 1'b1);

        // single-sample run, toggling sink
        for (int i = 0; i < 32; i++) xs[i] = DW'(-5 - i);
        run_case(1, 2, 1'b0);
        check(coef_bad == 0, "R5", "coefficient reads across all runs", coef_bad, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule